// File: doc/BRIEF.md
# Packet-Committed OUT Endpoint Receive FIFO

This block buffers the data of one USB OUT endpoint between the packet engine and a DMA-style port reader. The packet engine opens a transaction, and the block answers at once with an accept or NAK decision. The engine then pushes the payload one byte at a time and ends the transaction with either a close (good handshake) or an abort (bad CRC or no handshake). Bytes that arrive during an open transaction are stored but are hidden from the reader. When the transaction closes, the whole packet becomes readable in a single step. When it aborts, the partial bytes are thrown away.

Three pointers carry the state: a write pointer, a committed pointer and a read pointer. Each has one extra wrap bit. The reader sees a request line that is high while committed data is waiting. It pops one byte per acknowledged read, and it can keep draining older packets while a newer one is still arriving. A packet is accepted only when the FIFO has room for a maximum-size packet and the software NAK flag is clear. A short or empty packet raises that flag automatically, unless software has disabled the automatic setting. The storage holds `PKT_SLOTS` maximum-size packets, two by default.

Top module: `pkt_commit_rx_fifo`

## Requirements
- R1: Bytes written during an open transaction change neither `valid_cnt` nor `port_req`, including after the last byte of the packet.
- R2: In the cycle after an accepted transaction closes, `valid_cnt` rises by the number of bytes written in that transaction, all at once.
- R3: `port_req` is 1 exactly when `valid_cnt` is nonzero. `port_data` shows the oldest committed byte, in write order. A `port_rd` pulse while `port_req` is 1 removes that byte. With `GATE_DATA`=1, `port_data` is zero while `port_req` is 0.
- R4: A `port_rd` pulse while `port_req` is 0 has no effect on `valid_cnt`, `free_cnt` or the data later read.
- R5: Reading continues while a later transaction is open, and it stops (`port_req`=0) once the committed bytes are used up, even though uncommitted bytes are present.
- R6: `rx_accept` is 1 only when `force_nak` is 0 and `free_cnt` is at least `MAX_PKT`. A `txn_start` seen while `rx_accept` is 0 opens nothing, and bytes offered afterwards are not stored (`free_cnt` unchanged).
- R7: Closing an accepted transaction with `pkt_short`=1 while `auto_nak_dis`=0 sets `force_nak` on the next cycle. The flag stays set, NAKing later packets, until a `force_nak_clr` pulse clears it.
- R8: With `auto_nak_dis`=1, a short or zero-length close leaves `force_nak` at 0.
- R9: `txn_abort` on an open transaction discards its bytes: `free_cnt` returns to `DEPTH - valid_cnt`, and the next committed packet is read directly after the previously committed data.
- R10: `free_cnt` equals the storage depth minus all stored bytes, committed or not, and it counts down by one for each byte written.
- R11: A close with `pkt_short`=0 leaves `force_nak` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Packet engine begins an OUT data phase |
| rx_accept | output | 1 | 1 = packet would be accepted, 0 = NAK |
| wr_valid | input | 1 | Payload byte strobe |
| wr_data | input | DATA_W | Payload byte |
| txn_close | input | 1 | Transaction ended with a good handshake |
| txn_abort | input | 1 | Transaction failed; drop its bytes |
| pkt_short | input | 1 | Packet shorter than the maximum (valid with close) |
| auto_nak_dis | input | 1 | Software: disable automatic NAK on short packets |
| force_nak_clr | input | 1 | Software: clear the NAK flag |
| force_nak | output | 1 | NAK flag |
| port_req | output | 1 | Committed data available to the port |
| port_rd | input | 1 | Port consumes the byte on port_data |
| port_data | output | DATA_W | Oldest committed byte |
| valid_cnt | output | $clog2(MAX_PKT*PKT_SLOTS)+1 | Committed, unread byte count |
| free_cnt | output | $clog2(MAX_PKT*PKT_SLOTS)+1 | Free byte count |

## Verification
The bench sweeps every packet length from zero to the maximum, with the automatic NAK enabled and then disabled. This separates the visibility rule (counts frozen during writes, then a jump at close) from the flag rule (set only for short packets, and only when enabled). The data values encode the packet length and byte index, so ordering and wraparound errors show up on the read side. Further runs overlap draining with a later open transaction, fill the FIFO until it NAKs, and abort a partial packet. These separate the committed boundary from the write pointer, the room test from the flag test, and rollback from commit.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
   typedef enum logic {
      TXN_IDLE = 1'b0,
      TXN_OPEN = 1'b1
   } txn_state_e;
endpackage

// File: rtl/pcf_wr_ctrl.sv
module pcf_wr_ctrl
   import pcf_pkg::*;
#(
   parameter int PW = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          txn_start,
   input  logic          accept_ok,
   input  logic          wr_valid,
   input  logic          txn_close,
   input  logic          txn_abort,
   input  logic          room_ok,
   output logic [PW-1:0] wr_ptr,
   output logic [PW-1:0] cmt_ptr,
   output logic          wr_en,
   output logic          close_evt,
   output logic          txn_open
);
   txn_state_e    state_q;
   logic [PW-1:0] wr_next;

   assign txn_open  = (state_q == TXN_OPEN);
   assign wr_en     = txn_open && wr_valid && room_ok;
   assign wr_next   = wr_ptr + PW'(wr_en);
   assign close_evt = txn_open && txn_close && !txn_abort;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TXN_IDLE;
         wr_ptr  <= '0;
         cmt_ptr <= '0;
      end else if (txn_open && txn_abort) begin
         wr_ptr  <= cmt_ptr;
         state_q <= TXN_IDLE;
      end else if (close_evt) begin
         wr_ptr  <= wr_next;
         cmt_ptr <= wr_next;
         state_q <= TXN_IDLE;
      end else begin
         wr_ptr <= wr_next;
         if (!txn_open && txn_start && accept_ok)
            state_q <= TXN_OPEN;
      end
   end
endmodule

// File: rtl/pcf_nak_ctrl.sv
module pcf_nak_ctrl #(
   parameter int PW      = 4,
   parameter int MAX_PKT = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          close_evt,
   input  logic          pkt_short,
   input  logic          auto_nak_dis,
   input  logic          force_nak_clr,
   input  logic [PW-1:0] free_cnt,
   output logic          force_nak,
   output logic          accept_ok
);
   assign accept_ok = !force_nak && (free_cnt >= PW'(MAX_PKT));

   always_ff @(posedge clk) begin
      if (!rst_n)
         force_nak <= 1'b0;
      else if (close_evt && pkt_short && !auto_nak_dis)
         force_nak <= 1'b1;
      else if (force_nak_clr)
         force_nak <= 1'b0;
   end
endmodule

// File: rtl/pcf_rd_ctrl.sv
module pcf_rd_ctrl #(
   parameter int PW = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] cmt_ptr,
   input  logic          port_rd,
   output logic [PW-1:0] rd_ptr,
   output logic [PW-1:0] avail,
   output logic          port_req,
   output logic          rd_en
);
   assign avail    = cmt_ptr - rd_ptr;
   assign port_req = (avail != '0);
   assign rd_en    = port_rd && port_req;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_ptr <= '0;
      else if (rd_en)
         rd_ptr <= rd_ptr + 1'b1;
   end
endmodule

// File: rtl/pcf_store.sv
module pcf_store #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter bit GATE_DATA = 1'b1,
   localparam int AW       = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   input  logic              rd_live,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] raw;

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[wr_addr] <= wr_data;
   end

   assign raw = mem[rd_addr];

   generate
      if (GATE_DATA) begin : g_gated
         assign rd_data = rd_live ? raw : '0;
      end else begin : g_raw
         logic unused_live;
         assign unused_live = rd_live;
         assign rd_data     = raw;
      end
   endgenerate
endmodule

// File: rtl/pkt_commit_rx_fifo.sv
module pkt_commit_rx_fifo #(
   parameter int DATA_W    = 8,
   parameter int MAX_PKT   = 8,
   parameter int PKT_SLOTS = 2,
   parameter bit GATE_DATA = 1'b1,
   localparam int DEPTH    = MAX_PKT * PKT_SLOTS,
   localparam int AW       = $clog2(DEPTH),
   localparam int PW       = AW + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start,
   output logic              rx_accept,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              txn_close,
   input  logic              txn_abort,
   input  logic              pkt_short,
   input  logic              auto_nak_dis,
   input  logic              force_nak_clr,
   output logic              force_nak,
   output logic              port_req,
   input  logic              port_rd,
   output logic [DATA_W-1:0] port_data,
   output logic [PW-1:0]     valid_cnt,
   output logic [PW-1:0]     free_cnt
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (PKT_SLOTS < 2) begin : g_bad_slots
         $error("PKT_SLOTS must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("MAX_PKT*PKT_SLOTS must be a power of two");
      end
   endgenerate

   logic [PW-1:0] wr_ptr, cmt_ptr, rd_ptr, used;
   logic          wr_en, close_evt, txn_open, accept_ok, rd_en;

   assign used      = wr_ptr - rd_ptr;
   assign free_cnt  = PW'(DEPTH) - used;
   assign rx_accept = accept_ok;

   pcf_wr_ctrl #(.PW(PW)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .txn_start (txn_start),
      .accept_ok (accept_ok),
      .wr_valid  (wr_valid),
      .txn_close (txn_close),
      .txn_abort (txn_abort),
      .room_ok   (free_cnt != '0),
      .wr_ptr    (wr_ptr),
      .cmt_ptr   (cmt_ptr),
      .wr_en     (wr_en),
      .close_evt (close_evt),
      .txn_open  (txn_open)
   );

   pcf_nak_ctrl #(.PW(PW), .MAX_PKT(MAX_PKT)) u_nak (
      .clk           (clk),
      .rst_n         (rst_n),
      .close_evt     (close_evt),
      .pkt_short     (pkt_short),
      .auto_nak_dis  (auto_nak_dis),
      .force_nak_clr (force_nak_clr),
      .free_cnt      (free_cnt),
      .force_nak     (force_nak),
      .accept_ok     (accept_ok)
   );

   pcf_rd_ctrl #(.PW(PW)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmt_ptr  (cmt_ptr),
      .port_rd  (port_rd),
      .rd_ptr   (rd_ptr),
      .avail    (valid_cnt),
      .port_req (port_req),
      .rd_en    (rd_en)
   );

   pcf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .GATE_DATA(GATE_DATA)) u_mem (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_ptr[AW-1:0]),
      .wr_data (wr_data),
      .rd_addr (rd_ptr[AW-1:0]),
      .rd_live (port_req),
      .rd_data (port_data)
   );
endmodule

// File: rtl/pcf_chk.sv
module pcf_chk #(
   parameter int MAX_PKT = 8,
   parameter int DEPTH   = 16,
   parameter int PW      = 5
)(
   input logic          clk,
   input logic          rst_n,
   input logic          txn_open,
   input logic          txn_close,
   input logic          txn_abort,
   input logic          pkt_short,
   input logic          auto_nak_dis,
   input logic          force_nak,
   input logic          rx_accept,
   input logic          port_rd,
   input logic          port_req,
   input logic [PW-1:0] valid_cnt,
   input logic [PW-1:0] free_cnt
);
   AST_HIDDEN_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (!txn_close && !port_rd) |=> (valid_cnt == $past(valid_cnt))); // R1

   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (port_rd && !port_req && !txn_close) |=> (valid_cnt == '0)); // R4

   AST_ACCEPT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      rx_accept |-> (free_cnt >= PW'(MAX_PKT) && !force_nak)); // R6

   AST_SHORT_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_open && txn_close && !txn_abort && pkt_short && !auto_nak_dis) |=> force_nak); // R7

   AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_close && !pkt_short && force_nak) |=> force_nak); // R11

   AST_ABORT_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_open && txn_abort) |=> (free_cnt == PW'(DEPTH) - valid_cnt)); // R9

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, free_cnt} + {1'b0, valid_cnt}) <= (PW+1)'(DEPTH)); // R10
endmodule

bind pkt_commit_rx_fifo pcf_chk #(.MAX_PKT(MAX_PKT), .DEPTH(DEPTH), .PW(PW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .txn_open     (txn_open),
   .txn_close    (txn_close),
   .txn_abort    (txn_abort),
   .pkt_short    (pkt_short),
   .auto_nak_dis (auto_nak_dis),
   .force_nak    (force_nak),
   .rx_accept    (rx_accept),
   .port_rd      (port_rd),
   .port_req     (port_req),
   .valid_cnt    (valid_cnt),
   .free_cnt     (free_cnt)
);

// File: tb/tb_pkt_commit_rx_fifo.sv
module tb_pkt_commit_rx_fifo;
   localparam int MP = 4;
   localparam int DP = 8;
   localparam int PW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txn_start = 0, wr_valid = 0, txn_close = 0, txn_abort = 0;
   logic pkt_short = 0, auto_nak_dis = 0, force_nak_clr = 0, port_rd = 0;
   logic [7:0] wr_data = '0;
   logic rx_accept, force_nak, port_req;
   logic [7:0] port_data;
   logic [PW-1:0] valid_cnt, free_cnt;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   pkt_commit_rx_fifo #(.DATA_W(8), .MAX_PKT(MP), .PKT_SLOTS(2), .GATE_DATA(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .rx_accept(rx_accept),
      .wr_valid(wr_valid), .wr_data(wr_data), .txn_close(txn_close),
      .txn_abort(txn_abort), .pkt_short(pkt_short), .auto_nak_dis(auto_nak_dis),
      .force_nak_clr(force_nak_clr), .force_nak(force_nak), .port_req(port_req),
      .port_rd(port_rd), .port_data(port_data), .valid_cnt(valid_cnt), .free_cnt(free_cnt)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic start_txn(output bit acc);
      acc = rx_accept;
      txn_start = 1; step(); txn_start = 0;
   endtask

   task automatic put(input logic [7:0] b);
      wr_valid = 1; wr_data = b; step(); wr_valid = 0;
   endtask

   task automatic close_txn(input bit sh);
      txn_close = 1; pkt_short = sh; step(); txn_close = 0; pkt_short = 0;
   endtask

   task automatic pop(input logic [7:0] exp, input string req);
      chk(port_req == 1'b1, req, port_req, 1);
      chk(port_data == exp, req, port_data, exp);
      port_rd = 1; step(); port_rd = 0;
   endtask

   task automatic clr_nak();
      force_nak_clr = 1; step(); force_nak_clr = 0;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      bit acc;
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk(port_req == 0, "R3", port_req, 0);
      chk(valid_cnt == 0, "R2", valid_cnt, 0);
      chk(free_cnt == DP, "R10", free_cnt, DP);
      chk(force_nak == 0, "R7", force_nak, 0);
      chk(port_data == 0, "R3", port_data, 0);

      // sweep: every length, auto NAK on and off
      for (int dis = 0; dis < 2; dis++) begin
         auto_nak_dis = dis[0];
         for (int len = 0; len <= MP; len++) begin
            start_txn(acc);
            chk(acc == 1, "R6", acc, 1);
            for (int i = 0; i < len; i++) begin
               put(8'(len * 16 + i));
               chk(valid_cnt == 0 && port_req == 0, "R1", valid_cnt, 0);
               chk(free_cnt == DP - i - 1, "R10", free_cnt, DP - i - 1);
            end
            close_txn(len < MP);
            chk(valid_cnt == len, "R2", valid_cnt, len);
            if (len < MP && dis == 0)
               chk(force_nak == 1, "R7", force_nak, 1);
            else if (len < MP)
               chk(force_nak == 0, "R8", force_nak, 0);
            else
               chk(force_nak == 0, "R11", force_nak, 0);
            if (force_nak) begin
               start_txn(acc);
               chk(acc == 0, "R7", acc, 0);
               put(8'hEE);
               chk(free_cnt == DP - len, "R6", free_cnt, DP - len);
               close_txn(1'b1);
               clr_nak();
               chk(force_nak == 0 && rx_accept == 1, "R7", force_nak, 0);
            end
            for (int i = 0; i < len; i++) pop(8'(len * 16 + i), "R3");
            chk(port_req == 0, "R3", port_req, 1);
            port_rd = 1; step(); port_rd = 0;
            chk(valid_cnt == 0 && free_cnt == DP, "R4", free_cnt, DP);
         end
      end
      auto_nak_dis = 0;

      // drain during an open transaction
      start_txn(acc);
      for (int i = 0; i < MP; i++) put(8'(8'hA0 + i));
      close_txn(1'b0);
      start_txn(acc);
      chk(acc == 1, "R6", acc, 1);
      for (int i = 0; i < MP; i++) begin
         chk(port_data == 8'(8'hA0 + i), "R5", port_data, 8'hA0 + i);
         port_rd = 1;
         if (i < 2) begin wr_valid = 1; wr_data = 8'(8'hB0 + i); end
         step();
         port_rd = 0; wr_valid = 0;
      end
      chk(port_req == 0 && valid_cnt == 0, "R5", valid_cnt, 0);
      chk(free_cnt == DP - 2, "R10", free_cnt, DP - 2);
      port_rd = 1; step(); port_rd = 0;
      chk(free_cnt == DP - 2, "R4", free_cnt, DP - 2);
      put(8'hB2); put(8'hB3);
      close_txn(1'b0);
      chk(valid_cnt == MP, "R2", valid_cnt, MP);
      for (int i = 0; i < MP; i++) pop(8'(8'hB0 + i), "R5");

      // fill until NAK by lack of room
      start_txn(acc);
      for (int i = 0; i < MP; i++) put(8'(8'hC0 + i));
      close_txn(1'b0);
      start_txn(acc);
      for (int i = 0; i < MP; i++) put(8'(8'hD0 + i));
      close_txn(1'b0);
      chk(free_cnt == 0 && rx_accept == 0, "R6", free_cnt, 0);
      start_txn(acc);
      chk(acc == 0, "R6", acc, 0);
      put(8'hFF);
      chk(free_cnt == 0, "R6", free_cnt, 0);
      pop(8'hC0, "R3");
      chk(rx_accept == 0 && free_cnt == 1, "R6", free_cnt, 1);
      for (int i = 1; i < MP; i++) pop(8'(8'hC0 + i), "R3");
      chk(rx_accept == 1, "R6", rx_accept, 1);
      for (int i = 0; i < MP; i++) pop(8'(8'hD0 + i), "R3");

      // abort discards partial bytes
      auto_nak_dis = 1;
      start_txn(acc);
      put(8'h11); put(8'h12);
      close_txn(1'b1);
      chk(force_nak == 0, "R8", force_nak, 0);
      start_txn(acc);
      put(8'h21); put(8'h22); put(8'h23);
      chk(free_cnt == DP - 5, "R10", free_cnt, DP - 5);
      txn_abort = 1; step(); txn_abort = 0;
      chk(free_cnt == DP - 2 && valid_cnt == 2, "R9", free_cnt, DP - 2);
      start_txn(acc);
      put(8'h31);
      close_txn(1'b1);
      chk(valid_cnt == 3, "R9", valid_cnt, 3);
      pop(8'h11, "R9"); pop(8'h12, "R9"); pop(8'h31, "R9");
      chk(port_req == 0, "R9", port_req, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule